// File: doc/BRIEF.md
# Banked Level Interrupt Aggregator

This block collects a configurable number of level-sensitive interrupt sources (2 to 64) and folds them into one active-high level interrupt for a primary interrupt controller. It sits on an APB3 slave port. Every source passes two independent gates before it can raise the output: an enable bit, which must be 1, and a mask bit, which must be 0. Sources are split into two 32-bit banks. Sources 0 to 31 land in the low bank and sources 32 to 63 in the high bank, each at the bit position equal to the source number modulo 32.

Software reads a per-bank pending register that shows which sources are asserted, enabled and unmasked at that moment. Enable and mask bits exist only for sources below the configured count. Software can therefore find the count by writing all ones to both enable registers and reading them back. The output is not latched. It falls in the same cycle that the last qualifying source drops.

Top module: `irqagg_top`

## Requirements
- R1: The enable registers sit at offset 0x00 (low bank) and 0x04 (high bank), and the mask registers at 0x08 (low) and 0x0C (high). Source n maps to bit n%32 of the low bank when n<32 and of the high bank otherwise. Implemented bits read back the value last written.
- R2: Enable bits for sources at or above NUM_SRC have no storage. Writing 1 to them has no effect and they always read 0. With NUM_SRC of 32 or less, the whole high enable register reads 0.
- R3: Mask bits for sources at or above NUM_SRC also read 0 after any write.
- R4: The pending registers at 0x30 (low) and 0x34 (high) return, per bit, source AND enable AND NOT mask. They reflect the source inputs in the same cycle as the read.
- R5: A mask bit of 1 blocks its source from the pending register and from the output, even when the source is enabled.
- R6: irq_out is high exactly when any pending bit in either bank is 1. It is combinational, with no latching.
- R7: After reset, all enable and mask bits read 0 and irq_out is low.
- R8: pready is always 1 and pslverr is always 0.
- R9: Reads of any other offset return 0. Writes to other offsets or to the pending registers change no register.
- R10: A register is written only in the APB access phase (psel, penable and pwrite all high). A setup phase alone changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Always 0 |
| src_irq | input | NUM_SRC | Level sources, synchronous to pclk |
| irq_out | output | 1 | Aggregated active-high level interrupt |

## Verification
The bench targets the bank boundary, where source 32 must appear at bit 0 of the high register; a design with a swapped or shifted bank would report it in the wrong place. It runs count discovery on a 40-source and a 20-source instance, which would catch storage left in place for missing sources or a high bank that is not fully absent. It sets enable and mask to 1 on the same source to catch a reversed mask sense. It drops sources while enabled to catch a latched output. It also issues setup-only cycles, pending-register writes and unmapped accesses, which would reveal a write strobe that fires too early or an address decode that is too loose.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int BANK_W = 32;
  localparam int N_BANK = 2;
  localparam logic [11:0] OFF_EN_LO = 12'h000;
  localparam logic [11:0] OFF_EN_HI = 12'h004;
  localparam logic [11:0] OFF_MK_LO = 12'h008;
  localparam logic [11:0] OFF_MK_HI = 12'h00C;
  localparam logic [11:0] OFF_PD_LO = 12'h030;
  localparam logic [11:0] OFF_PD_HI = 12'h034;

  // Bits of a bank that correspond to an implemented source.
  function automatic logic [BANK_W-1:0] impl_bits(int nsrc, int bank);
    logic [BANK_W-1:0] m;
    m = '0;
    for (int i = 0; i < BANK_W; i++)
      if (bank * BANK_W + i < nsrc) m[i] = 1'b1;
    return m;
  endfunction

  // Qualification of one bank: raw AND enabled AND not masked.
  function automatic logic [BANK_W-1:0] qualify(logic [BANK_W-1:0] raw,
                                                logic [BANK_W-1:0] en,
                                                logic [BANK_W-1:0] mk);
    return raw & en & ~mk;
  endfunction
endpackage

// File: rtl/irqagg_bank.sv
module irqagg_bank
  import irqagg_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int BANK    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_we,
  input  logic              mk_we,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] en_q,
  output logic [BANK_W-1:0] mk_q
);
  localparam logic [BANK_W-1:0] IMPL = impl_bits(NUM_SRC, BANK);

  // Storage exists only for implemented sources.
  for (genvar i = 0; i < BANK_W; i++) begin : g_bit
    if (IMPL[i]) begin : g_ff
      logic en_r, mk_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          en_r <= 1'b0;
          mk_r <= 1'b0;
        end else begin
          if (en_we) en_r <= wdata[i];
          if (mk_we) mk_r <= wdata[i];
        end
      end
      assign en_q[i] = en_r;
      assign mk_q[i] = mk_r;
    end else begin : g_none
      assign en_q[i] = 1'b0;
      assign mk_q[i] = 1'b0;
    end
  end

  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> en_q == ($past(wdata) & IMPL)); // R1
  AST_MK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mk_we |=> mk_q == ($past(wdata) & IMPL)); // R3
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> $stable(en_q)); // R9
  AST_MK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mk_we |=> $stable(mk_q)); // R9
endmodule

// File: rtl/irqagg_status.sv
module irqagg_status
  import irqagg_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic [NUM_SRC-1:0]              src_irq,
  input  logic [N_BANK-1:0][BANK_W-1:0]   en_q,
  input  logic [N_BANK-1:0][BANK_W-1:0]   mk_q,
  output logic [N_BANK-1:0][BANK_W-1:0]   pend,
  output logic                            irq
);
  localparam int FULL_W = N_BANK * BANK_W;
  logic [FULL_W-1:0] src_w;
  assign src_w = FULL_W'(src_irq);

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    assign pend[b] = qualify(src_w[b*BANK_W +: BANK_W], en_q[b], mk_q[b]);
  end

  assign irq = |pend;
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int ADDR_W  = 12
) (
  input  logic               pclk,
  input  logic               presetn,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [31:0]        pwdata,
  output logic [31:0]        prdata,
  output logic               pready,
  output logic               pslverr,
  input  logic [NUM_SRC-1:0] src_irq,
  output logic               irq_out
);
  logic                          wr_acc, rd_acc;
  logic                          hit_en_lo, hit_en_hi, hit_mk_lo, hit_mk_hi;
  logic                          hit_pd_lo, hit_pd_hi, addr_hit;
  logic [N_BANK-1:0]             en_we, mk_we;
  logic [N_BANK-1:0][BANK_W-1:0] en_q, mk_q, pend;

  assign wr_acc = psel && penable && pwrite;
  assign rd_acc = psel && penable && !pwrite;

  assign hit_en_lo = (paddr == ADDR_W'(OFF_EN_LO));
  assign hit_en_hi = (paddr == ADDR_W'(OFF_EN_HI));
  assign hit_mk_lo = (paddr == ADDR_W'(OFF_MK_LO));
  assign hit_mk_hi = (paddr == ADDR_W'(OFF_MK_HI));
  assign hit_pd_lo = (paddr == ADDR_W'(OFF_PD_LO));
  assign hit_pd_hi = (paddr == ADDR_W'(OFF_PD_HI));
  assign addr_hit  = hit_en_lo | hit_en_hi | hit_mk_lo | hit_mk_hi |
                     hit_pd_lo | hit_pd_hi;

  assign en_we = {wr_acc && hit_en_hi, wr_acc && hit_en_lo};
  assign mk_we = {wr_acc && hit_mk_hi, wr_acc && hit_mk_lo};

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    irqagg_bank #(.NUM_SRC(NUM_SRC), .BANK(b)) u_bank (
      .clk   (pclk),
      .rst_n (presetn),
      .en_we (en_we[b]),
      .mk_we (mk_we[b]),
      .wdata (pwdata),
      .en_q  (en_q[b]),
      .mk_q  (mk_q[b])
    );
  end

  irqagg_status #(.NUM_SRC(NUM_SRC)) u_status (
    .src_irq (src_irq),
    .en_q    (en_q),
    .mk_q    (mk_q),
    .pend    (pend),
    .irq     (irq_out)
  );

  always_comb begin
    prdata = '0;
    unique case (1'b1)
      hit_en_lo: prdata = en_q[0];
      hit_en_hi: prdata = en_q[1];
      hit_mk_lo: prdata = mk_q[0];
      hit_mk_hi: prdata = mk_q[1];
      hit_pd_lo: prdata = pend[0];
      hit_pd_hi: prdata = pend[1];
      default:   prdata = '0;
    endcase
  end

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  AST_PEND_LO_READ: assert property (@(posedge pclk) disable iff (!presetn)
    (rd_acc && hit_pd_lo) |-> prdata == pend[0]); // R4
  AST_PEND_HI_READ: assert property (@(posedge pclk) disable iff (!presetn)
    (rd_acc && hit_pd_hi) |-> prdata == pend[1]); // R4
  AST_MASKED_QUIET: assert property (@(posedge pclk) disable iff (!presetn)
    ((pend[0] & mk_q[0]) == '0) && ((pend[1] & mk_q[1]) == '0)); // R5
  AST_IRQ_NEEDS_SRC: assert property (@(posedge pclk) disable iff (!presetn)
    irq_out |-> (|src_irq)); // R6
  AST_IRQ_NEEDS_EN: assert property (@(posedge pclk) disable iff (!presetn)
    irq_out |-> (|en_q)); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
    (rd_acc && !addr_hit) |-> prdata == '0); // R9
  AST_NO_SETUP_WRITE: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !penable) |=> ($stable(en_q) && $stable(mk_q))); // R10
endmodule

// File: tb/irqagg_top_tb.sv
`timescale 1ns/1ps
module irqagg_top_tb;
  localparam int NB = 40;
  localparam int NS = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, prdata_s;
  logic        pready, pslverr, pready_s, pslverr_s;
  logic [NB-1:0] src = '0;
  logic        irq, irq_s;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [63:0] en_m = '0, mk_m = '0;

  always #2 clk = ~clk;

  irqagg_top #(.NUM_SRC(NB), .ADDR_W(12)) u_dut (
    .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .src_irq(src), .irq_out(irq));

  irqagg_top #(.NUM_SRC(NS), .ADDR_W(12)) u_small (
    .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata_s),
    .pready(pready_s), .pslverr(pslverr_s), .src_irq(src[NS-1:0]),
    .irq_out(irq_s));

  function automatic logic [63:0] implemented(int n);
    logic [63:0] m = '0;
    for (int i = 0; i < 64; i++) m[i] = (i < n);
    return m;
  endfunction

  function automatic logic [63:0] expected_pend();
    return {24'b0, src} & en_m & ~mk_m;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(logic [11:0] a, output logic [31:0] d, output logic [31:0] ds);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    #0.5; d = prdata; ds = prdata_s;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic model_write(logic [11:0] a, logic [31:0] d);
    logic [63:0] im = implemented(NB);
    apb_write(a, d);
    case (a)
      12'h000: en_m[31:0]  = d & im[31:0];
      12'h004: en_m[63:32] = d & im[63:32];
      12'h008: mk_m[31:0]  = d & im[31:0];
      12'h00C: mk_m[63:32] = d & im[63:32];
      default: ;
    endcase
  endtask

  task automatic check_all(string req);
    logic [31:0] d, ds;
    logic [63:0] p = expected_pend();
    apb_read(12'h030, d, ds); check({req, " pend lo"}, {32'b0, d}, {32'b0, p[31:0]});
    apb_read(12'h034, d, ds); check({req, " pend hi"}, {32'b0, d}, {32'b0, p[63:32]});
    check({req, " irq"}, {63'b0, irq}, {63'b0, |p});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, ds;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R7 reset state
    apb_read(12'h000, d, ds); check("R7 en lo", {32'b0, d}, 0);
    apb_read(12'h00C, d, ds); check("R7 mk hi", {32'b0, d}, 0);
    check("R7 irq", {63'b0, irq}, 0);
    // R8 handshake
    check("R8 pready/pslverr", {62'b0, pready, pslverr}, 64'd2);
    // R2 count discovery on both instances
    model_write(12'h000, 32'hFFFF_FFFF);
    model_write(12'h004, 32'hFFFF_FFFF);
    apb_read(12'h004, d, ds);
    check("R2 en hi 40 src", {32'b0, d}, 64'h0000_00FF);
    check("R2 en hi 20 src", {32'b0, ds}, 0);
    apb_read(12'h000, d, ds);
    check("R1 en lo 40 src", {32'b0, d}, 64'hFFFF_FFFF);
    check("R2 en lo 20 src", {32'b0, ds}, 64'h000F_FFFF);
    // R3 mask storage limited
    model_write(12'h00C, 32'hFFFF_FFFF);
    apb_read(12'h00C, d, ds);
    check("R3 mk hi 40 src", {32'b0, d}, 64'h0000_00FF);
    model_write(12'h00C, 32'h0);
    model_write(12'h008, 32'h0);
    // R1/R4 bank boundary: source 32 -> high bit 0
    @(negedge clk); src = 40'h01_0000_0000;
    check_all("R4 src32");
    @(negedge clk); src = 40'h00_8000_0001;
    check_all("R4 src0/31");
    // R5 enabled and masked
    model_write(12'h008, 32'h0000_0001);
    @(negedge clk); src = 40'h00_0000_0001;
    check_all("R5 masked");
    // R6 drop releases immediately
    model_write(12'h008, 32'h0);
    @(negedge clk); src = 40'h00_0000_0001;
    #0.5; check("R6 irq high", {63'b0, irq}, 1);
    @(negedge clk); src = '0;
    #0.5; check("R6 irq low", {63'b0, irq}, 0);
    // R9 writes to pending and unmapped offsets ignored
    model_write(12'h030, 32'h0);
    model_write(12'h104, 32'h0);
    apb_read(12'h000, d, ds); check("R9 en kept", {32'b0, d}, 64'hFFFF_FFFF);
    apb_read(12'h010, d, ds); check("R9 unmapped read", {32'b0, d}, 0);
    // R10 setup-only cycle writes nothing
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 12'h000; pwdata = 32'h0;
    @(negedge clk); psel = 0; pwrite = 0;
    apb_read(12'h000, d, ds); check("R10 setup only", {32'b0, d}, 64'hFFFF_FFFF);
    // Random mix
    for (int it = 0; it < 300; it++) begin
      int op = int'($urandom % 5);
      logic [31:0] v = $urandom;
      case (op)
        0: model_write(12'h000, v);
        1: model_write(12'h004, v);
        2: model_write(12'h008, v);
        3: model_write(12'h00C, v);
        default: model_write(12'h030, v);
      endcase
      @(negedge clk); src = {8'($urandom), 32'($urandom)};
      check_all("R4 R5 R6 random");
      if (it % 25 == 0) begin
        apb_read(12'h008, d, ds); check("R1 mk lo", {32'b0, d}, {32'b0, mk_m[31:0]});
        apb_read(12'h004, d, ds); check("R1 en hi", {32'b0, d}, {32'b0, en_m[63:32]});
      end
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule